// File: doc/BRIEF.md
# Bus access violation capture unit

This unit collects reports of illegal bus accesses from a set of protected slave groups. Each report arrives as a one-cycle pulse that carries a violation index, a group number, the offending master and domain identifiers, the access direction and a 36-bit address. The unit sets a sticky status bit for the index and raises one level interrupt for every index that is not masked, while the unit is enabled. Software reads and clears these bits through a simple 32-bit register port.

Each group also keeps the detailed record of its first violation in a small memory, and raises a pending flag. Software copies a record into two debug registers with a handshake. It writes the one-hot group to a select register and starts the transfer. It polls until the done code appears, reads the debug words, stops the transfer and then clears the group's pending flag.

Register map (byte offsets, words 4 bytes apart): mask words from 0x000, status words from 0x400, debug word A at 0x900, debug word B at 0x904, control at 0xF00, group pending at 0xF10, group select at 0xF14 and transfer control at 0xF20. Index i lives in word i/32, bit i%32 of both the mask array and the status array. A read returns its data in the cycle after the read strobe.

Top module: `acc_vio_capture`

## Requirements
- R1: After reset all status bits, group pending bits, group select, the enable flag, the transfer control readback and the interrupt are 0. Every implemented mask bit is 1.
- R2: A violation pulse sets status bit (idx%32) of status word idx/32, whatever the enable flag. Writing a status word clears exactly the bits written as 1, and bits written as 0 keep their value.
- R3: Only the low NUM_IDX%32 bits of the last mask and status words exist. They read 0, and writes to them have no effect.
- R4: Mask words read back what was written. The interrupt is 1 one cycle after the enable flag is 1 and some status bit has a 0 mask bit. Otherwise it is 0.
- R5: A control write with bit 2 set clears the enable flag. A control write with bit 2 clear and bit 31 set sets it. Control bit 31 reads back the flag.
- R6: A violation sets the pending bit of its group, read at 0xF10. Writing 1s there clears those bits, and a write of 0 bits leaves them unchanged.
- R7: A group keeps the record of its first violation. Later violations of a pending group do not replace it.
- R8: Writing 1 to transfer control, while idle and with exactly one select bit set, makes it read 0x1 for SHIFT_CYC cycles. It then reads 0x3, and the debug words hold that group's record. Writing 0 returns the readback to 0x0.
- R9: Starting with no select bit or with several select bits set makes transfer control read 0x3 in the next cycle, and the debug words are left unchanged.
- R10: Debug word A holds, from bit 0 up: master ID (16 bits), domain ID (6 bits), a write flag, a read flag, address bits 35..32 and four 0 bits. Debug word B holds address bits 31..0.
- R11: When a violation and a status clear hit the same bit in one cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vio_vld | input | 1 | Violation report pulse |
| vio_idx | input | $clog2(NUM_IDX) | Violation index |
| vio_grp | input | $clog2(NUM_GRP) | Reporting group |
| vio_mst | input | 16 | Master ID |
| vio_dom | input | 6 | Domain ID |
| vio_wr | input | 1 | 1 for a write access, 0 for a read |
| vio_addr | input | 36 | Offending address |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_ren |
| irq | output | 1 | Violation interrupt |

## Verification
The bench builds the unit with NUM_IDX=70, NUM_GRP=4 and SHIFT_CYC=5. Seventy indices give three words, and the last word has only six live bits, so the edges of a partial word are easy to reach. Four groups take sixty random reports, so most groups are hit many times, which tests first-record retention. A five-cycle transfer lets the bench poll every cycle of the busy window and find the exact cycle the done code appears.

// File: rtl/acc_vio_pkg.sv
package acc_vio_pkg;

  localparam int MST_W   = 16;
  localparam int DOM_W   = 6;
  localparam int VADDR_W = 36;
  localparam int REG_AW  = 12;

  typedef struct packed {
    logic [VADDR_W-1:0] addr;
    logic               is_rd;
    logic               is_wr;
    logic [DOM_W-1:0]   dom;
    logic [MST_W-1:0]   mst;
  } vio_rec_t;

  localparam int REC_W = $bits(vio_rec_t);

  typedef enum logic [1:0] {
    SH_IDLE = 2'b00,
    SH_RUN  = 2'b01,
    SH_DONE = 2'b11
  } sh_state_e;

  localparam logic [REG_AW-1:0] ADR_DBG_A = 12'h900;
  localparam logic [REG_AW-1:0] ADR_DBG_B = 12'h904;
  localparam logic [REG_AW-1:0] ADR_CTRL  = 12'hF00;
  localparam logic [REG_AW-1:0] ADR_GPEND = 12'hF10;
  localparam logic [REG_AW-1:0] ADR_GSEL  = 12'hF14;
  localparam logic [REG_AW-1:0] ADR_XCTL  = 12'hF20;

  localparam int CTRL_STOP_BIT = 2;
  localparam int CTRL_RUN_BIT  = 31;

  function automatic logic [31:0] dbg_word_a(vio_rec_t r);
    return {4'b0000, r.addr[VADDR_W-1:32], r.is_rd, r.is_wr, r.dom, r.mst};
  endfunction

endpackage

// File: rtl/acc_vio_idx_bank.sv
module acc_vio_idx_bank #(
  parameter int NUM_IDX = 519,
  parameter int WORD_AW = 8,
  localparam int IDX_W  = $clog2(NUM_IDX),
  localparam int NWORDS = (NUM_IDX + 31) / 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_vld,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               wr_en,
  input  logic               wr_status,
  input  logic [WORD_AW-1:0] wr_word,
  input  logic [31:0]        wr_data,
  input  logic [WORD_AW-1:0] rd_word,
  output logic [31:0]        rd_mask,
  output logic [31:0]        rd_status,
  output logic               hit
);

  logic [NWORDS*32-1:0] st_flat;
  logic [NWORDS*32-1:0] mk_flat;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam int          LIVE = ((w + 1) * 32 > NUM_IDX) ? (NUM_IDX - w * 32) : 32;
    localparam logic [31:0] VM   = (LIVE == 32) ? 32'hFFFF_FFFF : ((32'd1 << LIVE) - 32'd1);

    logic [31:0] st_q, mk_q;
    logic [31:0] set_bits, clr_bits;
    logic        word_sel;

    assign word_sel = wr_en && (int'(wr_word) == w);

    always_comb begin
      set_bits = '0;
      if (set_vld && (int'(set_idx >> 5) == w))
        set_bits = 32'd1 << set_idx[4:0];
      clr_bits = (word_sel && wr_status) ? wr_data : 32'd0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q <= '0;
        mk_q <= VM;
      end else begin
        st_q <= ((st_q & ~clr_bits) | set_bits) & VM;
        if (word_sel && !wr_status)
          mk_q <= wr_data & VM;
      end
    end

    assign st_flat[w*32 +: 32] = st_q;
    assign mk_flat[w*32 +: 32] = mk_q;
  end

  always_comb begin
    rd_mask   = '0;
    rd_status = '0;
    if (int'(rd_word) < NWORDS) begin
      rd_mask   = mk_flat[int'(rd_word)*32 +: 32];
      rd_status = st_flat[int'(rd_word)*32 +: 32];
    end
  end

  assign hit = |(st_flat & ~mk_flat);

endmodule

// File: rtl/acc_vio_grp_store.sv
module acc_vio_grp_store import acc_vio_pkg::*; #(
  parameter int NUM_GRP = 8,
  localparam int GRP_W  = $clog2(NUM_GRP)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_vld,
  input  logic [GRP_W-1:0]   cap_grp,
  input  vio_rec_t           cap_rec,
  input  logic               clr_wr,
  input  logic [NUM_GRP-1:0] clr_bits,
  input  logic [GRP_W-1:0]   rd_grp,
  output vio_rec_t           rd_rec,
  output logic [NUM_GRP-1:0] pend
);

  logic [REC_W-1:0]   mem [NUM_GRP];
  logic [NUM_GRP-1:0] pend_q;
  logic [NUM_GRP-1:0] clr_eff;
  logic [NUM_GRP-1:0] set_eff;
  logic               grp_ok;
  logic               rec_we;
  logic [REC_W-1:0]   rd_q;

  assign grp_ok  = cap_vld && (int'(cap_grp) < NUM_GRP);
  assign clr_eff = clr_wr ? clr_bits : '0;

  always_comb begin
    set_eff = '0;
    if (grp_ok)
      set_eff[cap_grp] = 1'b1;
  end

  // A record is written only when the group holds none, or its old one
  // is being released in this very cycle.
  assign rec_we = grp_ok && (!pend_q[cap_grp] || clr_eff[cap_grp]);

  always_ff @(posedge clk) begin
    if (rst)
      pend_q <= '0;
    else
      pend_q <= (pend_q & ~clr_eff) | set_eff;
  end

  always_ff @(posedge clk) begin
    if (rec_we)
      mem[cap_grp] <= cap_rec;
    rd_q <= mem[rd_grp];
  end

  assign rd_rec = vio_rec_t'(rd_q);
  assign pend   = pend_q;

endmodule

// File: rtl/acc_vio_shift_fsm.sv
module acc_vio_shift_fsm import acc_vio_pkg::*; #(
  parameter int NUM_GRP   = 8,
  parameter int SHIFT_CYC = 8,
  localparam int GRP_W    = $clog2(NUM_GRP),
  localparam int CNT_W    = $clog2(SHIFT_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               stop,
  input  logic [NUM_GRP-1:0] sel,
  input  vio_rec_t           rd_rec,
  output logic [GRP_W-1:0]   rd_grp,
  output logic [1:0]         state,
  output vio_rec_t           dbg
);

  sh_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [GRP_W-1:0] grp_q;
  logic [GRP_W-1:0] sel_idx;
  logic             sel_ok;
  vio_rec_t         dbg_q;

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < NUM_GRP; i++)
      if (sel[i]) sel_idx = GRP_W'(i);
    sel_ok = ($countones(sel) == 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SH_IDLE;
      cnt_q <= '0;
      grp_q <= '0;
      dbg_q <= '0;
    end else if (stop) begin
      st_q <= SH_IDLE;
    end else begin
      unique case (st_q)
        SH_IDLE: begin
          if (start) begin
            if (sel_ok) begin
              st_q  <= SH_RUN;
              cnt_q <= '0;
              grp_q <= sel_idx;
            end else begin
              st_q <= SH_DONE;
            end
          end
        end
        SH_RUN: begin
          if (cnt_q == CNT_W'(SHIFT_CYC - 1)) begin
            st_q  <= SH_DONE;
            dbg_q <= rd_rec;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= SH_DONE;
      endcase
    end
  end

  assign rd_grp = grp_q;
  assign state  = st_q;
  assign dbg    = dbg_q;

endmodule

// File: rtl/acc_vio_capture.sv
module acc_vio_capture import acc_vio_pkg::*; #(
  parameter int NUM_IDX   = 519,
  parameter int NUM_GRP   = 8,
  parameter int SHIFT_CYC = 8,
  localparam int IDX_W    = $clog2(NUM_IDX),
  localparam int GRP_W    = $clog2(NUM_GRP)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vio_vld,
  input  logic [IDX_W-1:0]   vio_idx,
  input  logic [GRP_W-1:0]   vio_grp,
  input  logic [MST_W-1:0]   vio_mst,
  input  logic [DOM_W-1:0]   vio_dom,
  input  logic               vio_wr,
  input  logic [VADDR_W-1:0] vio_addr,
  input  logic               reg_wen,
  input  logic               reg_ren,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq
);

  localparam int WORD_AW = REG_AW - 4;

  logic               arr_wr;
  logic [31:0]        bank_mask, bank_stat;
  logic               raw_hit;
  logic               ctl_en;
  logic               ctl_stop_wr;
  logic               ctl_run_wr;
  logic [NUM_GRP-1:0] sh_sel;
  logic               sh_start, sh_stop;
  logic               pend_clr_wr;
  logic [NUM_GRP-1:0] grp_pend;
  logic [GRP_W-1:0]   rd_grp;
  logic [1:0]         sh_state;
  vio_rec_t           vio_rec, store_rec, dbg_rec;
  logic [31:0]        rd_mux;
  logic [31:0]        rdata_q;
  logic               irq_q;

  assign arr_wr      = reg_wen && (reg_addr[11] == 1'b0);
  assign ctl_stop_wr = reg_wen && (reg_addr == ADR_CTRL) && reg_wdata[CTRL_STOP_BIT];
  assign ctl_run_wr  = reg_wen && (reg_addr == ADR_CTRL) && reg_wdata[CTRL_RUN_BIT];
  assign sh_start    = reg_wen && (reg_addr == ADR_XCTL) && reg_wdata[0];
  assign sh_stop     = reg_wen && (reg_addr == ADR_XCTL) && !reg_wdata[0];
  assign pend_clr_wr = reg_wen && (reg_addr == ADR_GPEND);

  always_comb begin
    vio_rec       = '0;
    vio_rec.addr  = vio_addr;
    vio_rec.is_wr = vio_wr;
    vio_rec.is_rd = !vio_wr;
    vio_rec.dom   = vio_dom;
    vio_rec.mst   = vio_mst;
  end

  acc_vio_idx_bank #(
    .NUM_IDX (NUM_IDX),
    .WORD_AW (WORD_AW)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .set_vld   (vio_vld),
    .set_idx   (vio_idx),
    .wr_en     (arr_wr),
    .wr_status (reg_addr[10]),
    .wr_word   (reg_addr[WORD_AW+1:2]),
    .wr_data   (reg_wdata),
    .rd_word   (reg_addr[WORD_AW+1:2]),
    .rd_mask   (bank_mask),
    .rd_status (bank_stat),
    .hit       (raw_hit)
  );

  acc_vio_grp_store #(
    .NUM_GRP (NUM_GRP)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .cap_vld  (vio_vld),
    .cap_grp  (vio_grp),
    .cap_rec  (vio_rec),
    .clr_wr   (pend_clr_wr),
    .clr_bits (reg_wdata[NUM_GRP-1:0]),
    .rd_grp   (rd_grp),
    .rd_rec   (store_rec),
    .pend     (grp_pend)
  );

  acc_vio_shift_fsm #(
    .NUM_GRP   (NUM_GRP),
    .SHIFT_CYC (SHIFT_CYC)
  ) u_shift (
    .clk    (clk),
    .rst    (rst),
    .start  (sh_start),
    .stop   (sh_stop),
    .sel    (sh_sel),
    .rd_rec (store_rec),
    .rd_grp (rd_grp),
    .state  (sh_state),
    .dbg    (dbg_rec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en <= 1'b0;
      sh_sel <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctl_stop_wr)
        ctl_en <= 1'b0;
      else if (ctl_run_wr)
        ctl_en <= 1'b1;
      if (reg_wen && (reg_addr == ADR_GSEL))
        sh_sel <= reg_wdata[NUM_GRP-1:0];
      irq_q <= ctl_en && raw_hit;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr[11] == 1'b0) begin
      rd_mux = reg_addr[10] ? bank_stat : bank_mask;
    end else begin
      case (reg_addr)
        ADR_DBG_A: rd_mux = dbg_word_a(dbg_rec);
        ADR_DBG_B: rd_mux = dbg_rec.addr[31:0];
        ADR_CTRL:  rd_mux = {ctl_en, 31'd0};
        ADR_GPEND: rd_mux = 32'(grp_pend);
        ADR_GSEL:  rd_mux = 32'(sh_sel);
        ADR_XCTL:  rd_mux = {30'd0, sh_state};
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (reg_ren)
      rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;

endmodule

// File: rtl/acc_vio_capture_chk.sv
module acc_vio_capture_chk import acc_vio_pkg::*; #(
  parameter int NUM_GRP = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ctl_en,
  input logic               ctl_stop_wr,
  input logic               raw_hit,
  input logic               irq,
  input logic [1:0]         sh_state,
  input logic               sh_start,
  input logic               sh_stop,
  input logic [NUM_GRP-1:0] sh_sel,
  input vio_rec_t           dbg_rec,
  input logic               pend_clr_wr,
  input logic [NUM_GRP-1:0] grp_pend
);

  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl_en && raw_hit) |=> !irq);

  // R5
  ctl_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_stop_wr |=> !ctl_en);

  // R8
  sh_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_state == 2'b00 && sh_start && $onehot(sh_sel)) |=> (sh_state == 2'b01));

  // R9
  sh_nosel_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_state == 2'b00 && sh_start && !$onehot(sh_sel)) |=> (sh_state == 2'b11));

  // R8
  sh_done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_state == 2'b11 && !sh_stop) |=> (sh_state == 2'b11));

  // R8
  dbg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_state != 2'b01) |=> $stable(dbg_rec));

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_clr_wr |=> ((grp_pend & $past(grp_pend)) == $past(grp_pend)));

endmodule

bind acc_vio_capture acc_vio_capture_chk #(.NUM_GRP(NUM_GRP)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctl_en      (ctl_en),
  .ctl_stop_wr (ctl_stop_wr),
  .raw_hit     (raw_hit),
  .irq         (irq),
  .sh_state    (sh_state),
  .sh_start    (sh_start),
  .sh_stop     (sh_stop),
  .sh_sel      (sh_sel),
  .dbg_rec     (dbg_rec),
  .pend_clr_wr (pend_clr_wr),
  .grp_pend    (grp_pend)
);

// File: tb/acc_vio_capture_tb.sv
module acc_vio_capture_tb;

  localparam int NI = 70;
  localparam int NG = 4;
  localparam int SC = 5;
  localparam int NW = (NI + 31) / 32;

  localparam logic [11:0] A_MASK = 12'h000;
  localparam logic [11:0] A_STAT = 12'h400;
  localparam logic [11:0] A_DBGA = 12'h900;
  localparam logic [11:0] A_DBGB = 12'h904;
  localparam logic [11:0] A_CTRL = 12'hF00;
  localparam logic [11:0] A_PEND = 12'hF10;
  localparam logic [11:0] A_GSEL = 12'hF14;
  localparam logic [11:0] A_XCTL = 12'hF20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vio_vld = 1'b0;
  logic [6:0]  vio_idx = '0;
  logic [1:0]  vio_grp = '0;
  logic [15:0] vio_mst = '0;
  logic [5:0]  vio_dom = '0;
  logic        vio_wr = 1'b0;
  logic [35:0] vio_addr = '0;
  logic        reg_wen = 1'b0;
  logic        reg_ren = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  bit [NW*32-1:0] e_st;
  bit [NW*32-1:0] e_mk;
  bit [NG-1:0]    e_pend;
  bit [15:0]      r_mst [NG];
  bit [5:0]       r_dom [NG];
  bit             r_wr  [NG];
  bit [35:0]      r_adr [NG];

  acc_vio_capture #(.NUM_IDX(NI), .NUM_GRP(NG), .SHIFT_CYC(SC)) u_dut (
    .clk(clk), .rst(rst), .vio_vld(vio_vld), .vio_idx(vio_idx), .vio_grp(vio_grp),
    .vio_mst(vio_mst), .vio_dom(vio_dom), .vio_wr(vio_wr), .vio_addr(vio_addr),
    .reg_wen(reg_wen), .reg_ren(reg_ren), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic bit [31:0] live_mask(int w);
    bit [31:0] m = '0;
    for (int b = 0; b < 32; b++) if (w * 32 + b < NI) m[b] = 1'b1;
    return m;
  endfunction

  function automatic bit [31:0] exp_dbga(int g);
    return {4'b0, r_adr[g][35:32], !r_wr[g], r_wr[g], r_dom[g], r_mst[g]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_ren = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_ren = 1'b0;
  endtask

  task automatic model_viol(int idx, int g, bit [15:0] m, bit [5:0] dm, bit w, bit [35:0] ad);
    if (idx < NI) e_st[idx] = 1'b1;
    if (!e_pend[g]) begin
      e_pend[g] = 1'b1;
      r_mst[g] = m; r_dom[g] = dm; r_wr[g] = w; r_adr[g] = ad;
    end
  endtask

  task automatic viol(int idx, int g, bit [15:0] m, bit [5:0] dm, bit w, bit [35:0] ad);
    vio_vld = 1'b1; vio_idx = 7'(idx); vio_grp = 2'(g);
    vio_mst = m; vio_dom = dm; vio_wr = w; vio_addr = ad;
    @(negedge clk);
    vio_vld = 1'b0;
    model_viol(idx, g, m, dm, w, ad);
  endtask

  task automatic stat_clr(int w, bit [31:0] d);
    wr(A_STAT + 12'(4 * w), d);
    for (int b = 0; b < 32; b++) if (d[b] && (w * 32 + b < NI)) e_st[w * 32 + b] = 1'b0;
  endtask

  task automatic cmp_status(string req);
    logic [31:0] v;
    for (int w = 0; w < NW; w++) begin
      rd(A_STAT + 12'(4 * w), v);
      chk(req, v, e_st[w * 32 +: 32]);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] keep_a;
    void'($urandom(32'd1234));
    e_st = '0; e_pend = '0;
    for (int w = 0; w < NW; w++) e_mk[w * 32 +: 32] = live_mask(w);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    rd(A_MASK, v);          chk("R1 mask0", v, 32'hFFFF_FFFF);
    rd(A_MASK + 12'd8, v);  chk("R1 mask2", v, 32'h0000_003F);
    rd(A_STAT, v);          chk("R1 stat0", v, 32'h0);
    rd(A_CTRL, v);          chk("R1 ctrl", v, 32'h0);
    rd(A_PEND, v);          chk("R1 pend", v, 32'h0);
    rd(A_GSEL, v);          chk("R1 gsel", v, 32'h0);
    rd(A_XCTL, v);          chk("R1 xctl", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R3: partial last word
    wr(A_MASK + 12'd8, 32'hFFFF_FFFF);
    rd(A_MASK + 12'd8, v);  chk("R3 mask2 upper bits", v, 32'h0000_003F);
    wr(A_MASK + 12'd8, 32'h0000_0015);
    rd(A_MASK + 12'd8, v);  chk("R4 mask readback", v, 32'h0000_0015);
    wr(A_MASK + 12'd8, 32'hFFFF_FFFF);
    viol(69, 2, 16'h1111, 6'h01, 1'b1, 36'h1_0000_0045);
    rd(A_STAT + 12'd8, v);  chk("R3 stat2 idx69", v, 32'h0000_0020);
    stat_clr(2, 32'hFFFF_FFFF);
    rd(A_STAT + 12'd8, v);  chk("R2 stat2 w1c", v, 32'h0);

    // R11: set and clear on the same bit in one cycle
    viol(4, 1, 16'hABCD, 6'h2A, 1'b0, 36'hF_1234_5678);
    vio_vld = 1'b1; vio_idx = 7'd3; vio_grp = 2'd1;
    vio_mst = 16'h0001; vio_dom = 6'h01; vio_wr = 1'b1; vio_addr = 36'h0;
    reg_wen = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0000_0018;
    @(negedge clk);
    vio_vld = 1'b0; reg_wen = 1'b0;
    e_st[4] = 1'b0;
    model_viol(3, 1, 16'h0001, 6'h01, 1'b1, 36'h0);
    rd(A_STAT, v);          chk("R11 set beats clear", v, 32'h0000_0008);

    // R2 R6 R7: random reports
    for (int n = 0; n < 60; n++)
      viol(int'($urandom % NI), int'($urandom % NG), 16'($urandom), 6'($urandom),
           1'($urandom), {4'($urandom), 32'($urandom)});
    cmp_status("R2 random status");
    rd(A_PEND, v);          chk("R6 pending groups", v, 32'(e_pend));

    // R5: control
    wr(A_CTRL, 32'h8000_0000);
    rd(A_CTRL, v);          chk("R5 enable", v, 32'h8000_0000);
    wr(A_CTRL, 32'h8000_0004);
    rd(A_CTRL, v);          chk("R5 stop wins", v, 32'h0);
    wr(A_CTRL, 32'h8000_0000);

    // R4: interrupt
    idle(2);
    chk("R4 irq all masked", {31'd0, irq}, 32'h0);
    for (int w = 0; w < NW; w++) wr(A_MASK + 12'(4 * w), e_st[w * 32 +: 32]);
    idle(2);
    chk("R4 irq only set bits masked", {31'd0, irq}, 32'h0);
    for (int w = 0; w < NW; w++) wr(A_MASK + 12'(4 * w), 32'h0);
    idle(2);
    chk("R4 irq unmasked", {31'd0, irq}, {31'd0, |e_st});
    wr(A_CTRL, 32'h0000_0004);
    idle(2);
    chk("R4 irq disabled", {31'd0, irq}, 32'h0);
    wr(A_CTRL, 32'h8000_0000);

    // R2: random partial clears
    for (int w = 0; w < NW; w++) stat_clr(w, $urandom);
    cmp_status("R2 random w1c");
    for (int w = 0; w < NW; w++) stat_clr(w, 32'hFFFF_FFFF);
    cmp_status("R2 clear all");
    idle(2);
    chk("R4 irq after clear", {31'd0, irq}, 32'h0);

    // R6: writing 0 bits keeps pending
    wr(A_PEND, 32'h0);
    rd(A_PEND, v);          chk("R6 zero write", v, 32'(e_pend));

    // R7 R8 R10: drain groups lowest first
    while (e_pend != '0) begin
      int g = 0;
      for (int i = NG - 1; i >= 0; i--) if (e_pend[i]) g = i;
      wr(A_GSEL, 32'd1 << g);
      wr(A_XCTL, 32'd1);
      for (int k = 0; k < SC; k++) begin
        rd(A_XCTL, v);      chk("R8 busy", v, 32'h1);
      end
      rd(A_XCTL, v);        chk("R8 done", v, 32'h3);
      rd(A_DBGA, v);        chk("R10 R7 debug A", v, exp_dbga(g));
      rd(A_DBGB, v);        chk("R10 debug B", v, r_adr[g][31:0]);
      wr(A_XCTL, 32'd0);
      rd(A_XCTL, v);        chk("R8 stopped", v, 32'h0);
      wr(A_PEND, 32'd1 << g);
      e_pend[g] = 1'b0;
      rd(A_PEND, v);        chk("R6 group cleared", v, 32'(e_pend));
    end

    // R9: no or several groups selected
    rd(A_DBGA, keep_a);
    wr(A_GSEL, 32'h0);
    wr(A_XCTL, 32'd1);
    rd(A_XCTL, v);          chk("R9 none selected", v, 32'h3);
    rd(A_DBGA, v);          chk("R9 debug kept", v, keep_a);
    wr(A_XCTL, 32'd0);
    viol(10, 0, 16'h5555, 6'h15, 1'b1, 36'h2_0000_0010);
    wr(A_GSEL, 32'h5);
    wr(A_XCTL, 32'd1);
    rd(A_XCTL, v);          chk("R9 several selected", v, 32'h3);
    rd(A_DBGA, v);          chk("R9 debug kept multi", v, keep_a);
    wr(A_XCTL, 32'd0);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule